// File: doc/BRIEF.md
# Row Reduction over a Lane-Shift Chain

This block folds the partial sums held by a row of sixteen processing tiles into one central tile (index 7). Every tile owns a data section of sixteen signed 17-bit lanes and a communication section of sixteen 8-bit lanes. All communication sections together form one long lane-by-lane shift chain. To move a value, a sender copies one slice of its data into its communication section. The whole chain then shifts one lane per cycle toward the receiver. Once the transfer is complete, the receiver adds the arriving slice into its own data section.

The reduction runs as four branches with hop distances of 1, 2, 4 and 8 tiles. The pattern is mirrored on both sides of the centre tile, so the sums close in on tile 7 from both directions. The centre tile has only one communication section, so each branch makes two passes: first the tiles above the centre shift toward lower indices, then the tiles below it shift toward higher indices. Each value travels as three 8-bit slices, low slice first, with the carry kept per lane between slices.

A host writes the partial sums one tile at a time while the block is idle, pulses start, waits for done, and reads any tile back. A mode input chosen at start labels the chain as horizontal (east/west) or vertical (north/south). The label is reported on a direction output that is set before every pass.

Top module: `shift_reduce_row`

## Requirements
- R1: After reset, busy and done are 0, linkDir is 0, and every lane of every tile reads 0.
- R2: While busy is 0, a cycle with loadEn high writes loadData into the tile selected by loadTile. Lane l occupies bits [17l+16:17l]. readData always shows the tile selected by readTile, with the same layout.
- R3: When done rises, every lane l of tile 7 holds the sum of lane l over all sixteen tiles' loaded values, wrapped to 17-bit two's complement.
- R4: Let p be a tile's distance from tile 7 on its own side. In branch b (b = 0..3, span 2^b), a tile with p mod 2^(b+1) = 2^b sends to the tile at distance p - 2^b on the same side, which adds the value. Tile 7 never sends. All other tiles hold their data, so after done each non-centre tile holds its own value plus everything it received.
- R5: done rises exactly 1488 cycles after the clock edge that samples start. Each branch makes two passes, each pass carries three slices, and each slice costs one copy cycle, 16·2^b shift cycles and one add cycle.
- R6: linkDir uses the encoding 0 north, 1 east, 2 south, 3 west. In row mode (vertMode 0) it reads 3 during the pass toward lower tile indices and 1 during the pass toward higher indices. In column mode it reads 0 and 2 for those passes. It is set before a pass's first shift and does not change while the pass shifts.
- R7: Values are moved in 8-bit slices with a per-lane carry, so sums that cross slice boundaries, negative values and sums beyond the 17-bit range all give the wrapped 17-bit result.
- R8: busy rises on the edge after an accepted start, and done clears on that same edge. done stays high until the next accepted start. A start pulse while busy is ignored and does not change the latency.
- R9: loadEn while busy is ignored: no tile's data changes because of it.
- R10: vertMode is sampled only on the edge that accepts start; changing it during a run does not change linkDir.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a reduction (accepted when idle) |
| vertMode | input | 1 | 0 row labelling (east/west), 1 column labelling (north/south) |
| loadEn | input | 1 | Write loadData into tile loadTile (idle only) |
| loadTile | input | 4 | Tile written by a load |
| loadData | input | 272 | Sixteen 17-bit lanes to write |
| readTile | input | 4 | Tile shown on readData |
| readData | output | 272 | Sixteen 17-bit lanes of the selected tile |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | Reduction finished, held until next start |
| linkDir | output | 2 | Configured transfer direction |

## Verification
Assertions in the RTL check the following on every cycle:
- the shift counter stays below the hop length of the current branch;
- linkDir holds steady while a pass shifts;
- done and busy are never high together, and an accepted start raises busy and clears done;
- the centre tile places nothing on the chain;
- no tile's data moves while busy except on an add cycle.

Several behaviours can only be shown by the bench scenarios: the arithmetic result across slice carries and 17-bit wrap, the exact branch schedule as seen in every tile's final contents, the 1488-cycle latency, and the direction labels for each mode. The bench also shows that start, load and mode inputs have no effect while a run is in flight.

// File: rtl/srr_pkg.sv
package srr_pkg;

  localparam int BRANCH_IW = 4;
  localparam int SLICE_IW  = 4;

  typedef enum logic [1:0] {
    DIR_NORTH = 2'd0,
    DIR_EAST  = 2'd1,
    DIR_SOUTH = 2'd2,
    DIR_WEST  = 2'd3
  } linkDir_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic                 loadComm;
    logic                 shiftEn;
    logic                 addEn;
    logic                 westPass;   // 1: chain moves toward lower tile index
    logic [SLICE_IW-1:0]  sliceIdx;
    logic [BRANCH_IW-1:0] branchIdx;
  } ctrlStrobe_t;

  function automatic linkDir_e dirFor(input logic westPass, input logic vertMode);
    if (vertMode) return westPass ? DIR_NORTH : DIR_SOUTH;
    return westPass ? DIR_WEST : DIR_EAST;
  endfunction

  // Distance of a tile from the centre on the side the pass drains
  function automatic int sideDist(input int tile, input int center, input logic westPass);
    return westPass ? (tile - center) : (center - tile);
  endfunction

  function automatic logic isSender(input int tile, input int center,
                                    input int branch, input logic westPass);
    int p;
    int span;
    p    = sideDist(tile, center, westPass);
    span = 1 << branch;
    return (p >= 1) && ((p % (2 * span)) == span);
  endfunction

  function automatic logic isReceiver(input int tile, input int center, input int branch,
                                      input logic westPass, input int numTiles);
    int p;
    int span;
    int partner;
    p       = sideDist(tile, center, westPass);
    span    = 1 << branch;
    partner = westPass ? (tile + span) : (tile - span);
    return (p >= 0) && ((p % (2 * span)) == 0) && (partner >= 0) && (partner < numTiles);
  endfunction

endpackage

// File: rtl/srr_ctrl.sv
module srr_ctrl
  import srr_pkg::*;
#(
  parameter int LANES      = 16,
  parameter int NUM_BRANCH = 4,
  parameter int NUM_SLICES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        vertMode,
  output ctrlStrobe_t stb,
  output logic        busy,
  output logic        done,
  output linkDir_e    linkDir
);

  localparam int MAX_SHIFT = LANES << (NUM_BRANCH - 1);
  localparam int CNT_W     = $clog2(MAX_SHIFT) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_ADD} state_e;

  state_e               stateQ;
  logic [BRANCH_IW-1:0] branchQ;
  logic [SLICE_IW-1:0]  sliceQ;
  logic                 westQ;
  logic                 vertQ;
  logic [CNT_W-1:0]     cntQ;
  logic                 doneQ;
  linkDir_e             dirQ;

  logic [CNT_W-1:0] hopShifts;
  logic             lastShift;
  logic             lastSlice;
  logic             lastBranch;

  always_comb begin
    hopShifts  = CNT_W'(LANES) << branchQ;
    lastShift  = (cntQ == hopShifts - CNT_W'(1));
    lastSlice  = (sliceQ == SLICE_IW'(NUM_SLICES - 1));
    lastBranch = (branchQ == BRANCH_IW'(NUM_BRANCH - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      branchQ <= '0;
      sliceQ  <= '0;
      westQ   <= 1'b1;
      vertQ   <= 1'b0;
      cntQ    <= '0;
      doneQ   <= 1'b0;
      dirQ    <= DIR_NORTH;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (start) begin
            stateQ  <= ST_LOAD;
            branchQ <= '0;
            sliceQ  <= '0;
            westQ   <= 1'b1;
            vertQ   <= vertMode;
            dirQ    <= dirFor(1'b1, vertMode);
            doneQ   <= 1'b0;
          end
        end
        ST_LOAD: begin
          stateQ <= ST_SHIFT;
          cntQ   <= '0;
        end
        ST_SHIFT: begin
          cntQ <= cntQ + CNT_W'(1);
          if (lastShift) stateQ <= ST_ADD;
        end
        ST_ADD: begin
          if (!lastSlice) begin
            sliceQ <= sliceQ + SLICE_IW'(1);
            stateQ <= ST_LOAD;
          end else begin
            sliceQ <= '0;
            if (westQ) begin
              westQ  <= 1'b0;
              dirQ   <= dirFor(1'b0, vertQ);
              stateQ <= ST_LOAD;
            end else if (!lastBranch) begin
              branchQ <= branchQ + BRANCH_IW'(1);
              westQ   <= 1'b1;
              dirQ    <= dirFor(1'b1, vertQ);
              stateQ  <= ST_LOAD;
            end else begin
              stateQ <= ST_IDLE;
              doneQ  <= 1'b1;
            end
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb           = '0;
    stb.loadComm  = (stateQ == ST_LOAD);
    stb.shiftEn   = (stateQ == ST_SHIFT);
    stb.addEn     = (stateQ == ST_ADD);
    stb.westPass  = westQ;
    stb.sliceIdx  = sliceQ;
    stb.branchIdx = branchQ;
  end

  assign busy    = (stateQ != ST_IDLE);
  assign done    = doneQ;
  assign linkDir = dirQ;

  AST_SHIFT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SHIFT) |-> (cntQ < hopShifts)); // R5
  AST_BRANCH_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (branchQ < BRANCH_IW'(NUM_BRANCH))); // R4
  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftEn |=> $stable(linkDir)); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R8
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && !done)); // R8

endmodule

// File: rtl/srr_datapath.sv
module srr_datapath
  import srr_pkg::*;
#(
  parameter int NUM_TILES  = 16,
  parameter int LANES      = 16,
  parameter int DATA_W     = 17,
  parameter int LINK_W     = 8,
  parameter int CENTER     = 7,
  parameter int NUM_SLICES = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctrlStrobe_t                       stb,
  input  logic                              busy,
  input  logic                              loadEn,
  input  logic [$clog2(NUM_TILES)-1:0]      loadTile,
  input  logic [LANES*DATA_W-1:0]           loadData,
  input  logic [$clog2(NUM_TILES)-1:0]      readTile,
  output logic [LANES*DATA_W-1:0]           readData
);

  localparam int TILE_IW     = $clog2(NUM_TILES);
  localparam int TILE_W      = LANES * DATA_W;
  localparam int TOTAL_LANES = NUM_TILES * LANES;
  localparam int PAD_W       = NUM_SLICES * LINK_W;
  localparam int COMM_W      = TOTAL_LANES * LINK_W;
  localparam int FLAT_W      = TOTAL_LANES * DATA_W;

  logic [DATA_W-1:0] dataQ     [NUM_TILES][LANES];
  logic [DATA_W-1:0] nextData  [NUM_TILES][LANES];
  logic              carryQ    [NUM_TILES][LANES];
  logic              nextCarry [NUM_TILES][LANES];
  logic [COMM_W-1:0] commQ;
  logic [COMM_W-1:0] loadVec;
  logic [FLAT_W-1:0] dataFlat;
  logic [NUM_TILES-1:0] sendMask;
  logic [NUM_TILES-1:0] recvMask;
  logic wrEn;

  assign wrEn = loadEn && !busy;

  // Role of each tile in the current branch and pass
  for (genvar t = 0; t < NUM_TILES; t++) begin : g_role
    assign sendMask[t] = isSender(t, CENTER, int'(stb.branchIdx), stb.westPass);
    assign recvMask[t] = isReceiver(t, CENTER, int'(stb.branchIdx), stb.westPass, NUM_TILES);
  end

  function automatic logic [PAD_W-1:0] widen(input logic [DATA_W-1:0] v);
    return PAD_W'(signed'(v));
  endfunction

  // Slice extraction for senders and slice addition for receivers
  always_comb begin
    for (int t = 0; t < NUM_TILES; t++) begin
      for (int l = 0; l < LANES; l++) begin
        logic [PAD_W-1:0]  padV;
        logic [LINK_W-1:0] ownSlice;
        logic [LINK_W-1:0] arrived;
        logic              cin;
        logic [LINK_W:0]   sumV;
        padV     = widen(dataQ[t][l]);
        ownSlice = padV[stb.sliceIdx*LINK_W +: LINK_W];
        arrived  = commQ[(t*LANES+l)*LINK_W +: LINK_W];
        loadVec[(t*LANES+l)*LINK_W +: LINK_W] = sendMask[t] ? ownSlice : '0;
        cin  = (stb.sliceIdx == '0) ? 1'b0 : carryQ[t][l];
        sumV = {1'b0, ownSlice} + {1'b0, arrived} + {{LINK_W{1'b0}}, cin};
        padV[stb.sliceIdx*LINK_W +: LINK_W] = sumV[LINK_W-1:0];
        nextData[t][l]  = padV[DATA_W-1:0];
        nextCarry[t][l] = sumV[LINK_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < NUM_TILES; t++) begin
        for (int l = 0; l < LANES; l++) begin
          dataQ[t][l]  <= '0;
          carryQ[t][l] <= 1'b0;
        end
      end
    end else begin
      for (int t = 0; t < NUM_TILES; t++) begin
        for (int l = 0; l < LANES; l++) begin
          if (wrEn && (loadTile == TILE_IW'(t))) begin
            dataQ[t][l] <= loadData[l*DATA_W +: DATA_W];
          end else if (stb.addEn && recvMask[t]) begin
            dataQ[t][l]  <= nextData[t][l];
            carryQ[t][l] <= nextCarry[t][l];
          end
        end
      end
    end
  end

  // Lane-by-lane shift chain across all tiles
  always_ff @(posedge clk) begin
    if (!rstN) begin
      commQ <= '0;
    end else if (stb.loadComm) begin
      commQ <= loadVec;
    end else if (stb.shiftEn) begin
      if (stb.westPass) commQ <= {{LINK_W{1'b0}}, commQ[COMM_W-1:LINK_W]};
      else              commQ <= {commQ[COMM_W-LINK_W-1:0], {LINK_W{1'b0}}};
    end
  end

  always_comb begin
    for (int t = 0; t < NUM_TILES; t++) begin
      for (int l = 0; l < LANES; l++) begin
        dataFlat[(t*LANES+l)*DATA_W +: DATA_W] = dataQ[t][l];
      end
    end
  end

  assign readData = dataFlat[readTile*TILE_W +: TILE_W];

  AST_CENTRE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadComm |=> (commQ[CENTER*LANES*LINK_W +: LANES*LINK_W] == '0)); // R4
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stb.addEn) |=> $stable(dataFlat)); // R9

endmodule

// File: rtl/shift_reduce_row.sv
module shift_reduce_row
  import srr_pkg::*;
#(
  parameter int NUM_TILES = 16,
  parameter int LANES     = 16,
  parameter int DATA_W    = 17,
  parameter int LINK_W    = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic                          vertMode,
  input  logic                          loadEn,
  input  logic [$clog2(NUM_TILES)-1:0]  loadTile,
  input  logic [LANES*DATA_W-1:0]       loadData,
  input  logic [$clog2(NUM_TILES)-1:0]  readTile,
  output logic [LANES*DATA_W-1:0]       readData,
  output logic                          busy,
  output logic                          done,
  output logic [1:0]                    linkDir
);

  localparam int CENTER     = NUM_TILES / 2 - 1;
  localparam int NUM_SLICES = (DATA_W + LINK_W - 1) / LINK_W;
  localparam int NUM_BRANCH = $clog2(NUM_TILES - 1 - CENTER) + 1;

  ctrlStrobe_t stb;
  linkDir_e    dirE;

  srr_ctrl #(
    .LANES      (LANES),
    .NUM_BRANCH (NUM_BRANCH),
    .NUM_SLICES (NUM_SLICES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .vertMode (vertMode),
    .stb      (stb),
    .busy     (busy),
    .done     (done),
    .linkDir  (dirE)
  );

  srr_datapath #(
    .NUM_TILES  (NUM_TILES),
    .LANES      (LANES),
    .DATA_W     (DATA_W),
    .LINK_W     (LINK_W),
    .CENTER     (CENTER),
    .NUM_SLICES (NUM_SLICES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busy     (busy),
    .loadEn   (loadEn),
    .loadTile (loadTile),
    .loadData (loadData),
    .readTile (readTile),
    .readData (readData)
  );

  assign linkDir = 2'(dirE);

endmodule

// File: tb/shift_reduce_row_tb.sv
module shift_reduce_row_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NT  = 16;
  localparam int NL  = 16;
  localparam int DW  = 17;
  localparam int TW  = NL * DW;
  localparam int CTR = 7;
  localparam int MASK = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          vertMode = 1'b0;
  logic          loadEn = 1'b0;
  logic [3:0]    loadTile = '0;
  logic [TW-1:0] loadData = '0;
  logic [3:0]    readTile = '0;
  logic [TW-1:0] readData;
  logic          busy;
  logic          done;
  logic [1:0]    linkDir;

  always #2 clk = ~clk;

  shift_reduce_row u_dut (
    .clk(clk), .rstN(rstN), .start(start), .vertMode(vertMode),
    .loadEn(loadEn), .loadTile(loadTile), .loadData(loadData),
    .readTile(readTile), .readData(readData),
    .busy(busy), .done(done), .linkDir(linkDir)
  );

  typedef struct {
    int            tile;
    logic [TW-1:0] exp;
    string         tag;
  } sbItem_t;

  sbItem_t sbQ[$];
  int  checks = 0;
  int  errors = 0;
  bit  monBusy = 0;
  bit  drainReq = 0;
  bit  finished = 0;
  int  model[NT][NL];
  int  seed = 32'h1357;

  task automatic checkVal(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  function automatic logic [TW-1:0] packTile(input int t);
    logic [TW-1:0] v;
    for (int l = 0; l < NL; l++) v[l*DW +: DW] = DW'(model[t][l]);
    return v;
  endfunction

  function automatic int expLatency();
    int s = 0;
    for (int b = 0; b < 4; b++) s += 2 * 3 * (16 * (1 << b) + 2);
    return s;
  endfunction

  // Monitor: drains the scoreboard when done rises or on request
  initial begin
    bit prevDone = 0;
    forever begin
      @(negedge clk);
      if ((done && !prevDone) || drainReq) begin
        monBusy = 1;
        while (sbQ.size() > 0) begin
          sbItem_t it;
          it = sbQ.pop_front();
          readTile = 4'(it.tile);
          #1;
          checks++;
          if (readData !== it.exp) begin
            errors++;
            $display("FAIL %s tile %0d got %h exp %h", it.tag, it.tile, readData, it.exp);
          end
          @(negedge clk);
        end
        drainReq = 0;
        monBusy = 0;
      end
      prevDone = done;
    end
  end

  function automatic int genVal(input int pat, input int t, input int l);
    case (pat)
      0: return (t + 1) * (l + 1);
      1: begin
           seed = seed * 1103515245 + 12345;
           return (seed >>> 7) & MASK;
         end
      2: return MASK;            // -1
      default: return 17'h0FFFF; // largest positive
    endcase
  endfunction

  // Reference schedule computed from the requirement text
  task automatic modelReduce();
    for (int b = 0; b < 4; b++) begin
      int span = 1 << b;
      for (int p = 1; CTR + p < NT; p++)
        if ((p % (2 * span)) == span)
          for (int l = 0; l < NL; l++)
            model[CTR+p-span][l] = (model[CTR+p-span][l] + model[CTR+p][l]) & MASK;
      for (int p = 1; CTR - p >= 0; p++)
        if ((p % (2 * span)) == span)
          for (int l = 0; l < NL; l++)
            model[CTR-p+span][l] = (model[CTR-p+span][l] + model[CTR-p][l]) & MASK;
    end
  endtask

  task automatic loadAll(input int pat);
    for (int t = 0; t < NT; t++) begin
      for (int l = 0; l < NL; l++) model[t][l] = genVal(pat, t, l);
      @(negedge clk);
      loadEn = 1'b1;
      loadTile = 4'(t);
      loadData = packTile(t);
    end
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  // Driver: loads tiles, pushes expected results, runs one reduction
  task automatic runReduction(input int pat, input bit vert, input bit poke);
    int  k;
    bit  got;
    loadAll(pat);
    modelReduce();
    for (int t = 0; t < NT; t++) begin
      sbItem_t it;
      it.tile = t;
      it.exp  = packTile(t);
      it.tag  = (t == CTR) ? ((pat >= 2) ? "R3/R7" : "R3") : "R4";
      sbQ.push_back(it);
    end
    @(negedge clk);
    start = 1'b1;
    vertMode = vert;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    got = 0;
    while (k < 4000 && !got) begin
      @(negedge clk);
      k++;
      if (done) got = 1;
      else begin
        if (k == 1) begin
          checkVal("R8", "busy after start", int'(busy), 1);
          checkVal("R8", "done cleared by start", int'(done), 0);
        end
        if (k == 5) vertMode = ~vert;
        if (k == 10) checkVal("R6", "dir pass to lower", int'(linkDir), vert ? 0 : 3);
        if (k == 60) checkVal(vert ? "R10" : "R6", "dir pass to higher", int'(linkDir), vert ? 2 : 1);
        if (poke) begin
          if (k == 20) begin
            loadEn = 1'b1;
            loadTile = 4'(CTR);
            loadData = {TW{1'b1}};
          end
          if (k == 21) loadEn = 1'b0;
          if (k == 30) start = 1'b1;
          if (k == 31) start = 1'b0;
        end
      end
    end
    checkVal("R5", "cycles to done", k, expLatency());
    wait (sbQ.size() == 0 && !monBusy);
    checkVal("R8", "done held", int'(done), 1);
    checkVal("R8", "busy low after done", int'(busy), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkVal("R1", "busy", int'(busy), 0);
    checkVal("R1", "done", int'(done), 0);
    checkVal("R1", "linkDir", int'(linkDir), 0);
    for (int t = 0; t < NT; t += 5) begin
      sbItem_t it;
      it.tile = t; it.exp = '0; it.tag = "R1";
      sbQ.push_back(it);
    end
    drainReq = 1;
    wait (drainReq == 0);

    // R2 load and read back while idle
    for (int l = 0; l < NL; l++) model[3][l] = (l * 7919 + 5) & MASK;
    @(negedge clk);
    loadEn = 1'b1; loadTile = 4'd3; loadData = packTile(3);
    @(negedge clk);
    loadEn = 1'b0;
    begin
      sbItem_t it;
      it.tile = 3; it.exp = packTile(3); it.tag = "R2";
      sbQ.push_back(it);
    end
    drainReq = 1;
    wait (drainReq == 0);

    runReduction(0, 1'b0, 1'b0); // small positive values, row mode
    runReduction(1, 1'b1, 1'b0); // full-range values, column mode, R10 mode flip
    runReduction(2, 1'b0, 1'b1); // all -1, busy pokes (R8, R9)
    runReduction(3, 1'b1, 1'b0); // wrap beyond 17 bits (R7)

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule